// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block translates I/O virtual addresses issued by a client master into physical addresses, one 4 KiB page at a time. A fixed window of the address space (the aperture) starts at a parameterised base and covers a parameterised number of pages. Each page has one table entry. An entry holds a valid flag and the physical frame that the page maps to. Requests whose bytes all fall inside the aperture and land on a valid entry come back translated. Every other request comes back as a fault.

Software never addresses the table directly. It uses a small slave port with three 32-bit registers. An enable register turns translation on and off, and a read of it also serves as a read-back point. An entry-pointer register takes a byte address inside the aperture. An entry-data register writes or reads the entry that the pointer selects. To map a page, software writes the pointer and then the data. To unmap it, software writes zero.

Top module: `aperture_remap`

## Requirements
- R1: After reset the enable bit is 0 and every entry is invalid: an entry-data read returns 0 and every translation request faults.
- R2: Register byte offset 0x0 (`reg_addr[3:2]`=0) is the enable register. A write stores `reg_wdata[0]`, and a read returns `{31'b0, enable}`.
- R3: Offset 0x4 is the entry pointer. A write stores the full 32-bit byte address, and a read returns it unchanged.
- R4: A write to offset 0x8 stores `reg_wdata[31:12]` into the entry with index (pointer − base) >> 12. A read of offset 0x8 returns that entry with bits 11:0 as zero. Register read data appears on `reg_rdata` one cycle after the read strobe.
- R5: When the pointer lies outside the aperture, a write to offset 0x8 changes no entry and a read of offset 0x8 returns 0.
- R6: A response follows each request exactly one cycle later (`rsp_valid`). On a hit, `rsp_paddr` = {1'b0, entry bits 30:12, request bits 11:0}.
- R7: While the enable bit is 0, every request faults.
- R8: A request faults unless its first byte (`req_addr`) is at or above the base and its last byte (`req_addr + req_len`) is below base + pages×4096. Every faulting response drives `rsp_paddr` to zero.
- R9: A request faults when the selected entry has bit 31 clear. Writing an all-zero entry unmaps a page that was mapped before.
- R10: The low 12 address bits pass through translation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset; only aligned offsets decode |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | I/O virtual byte address |
| req_len | input | 12 | Access length in bytes minus one |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_fault | output | 1 | Request rejected |
| rsp_paddr | output | 32 | Translated physical address, zero on a fault |

## Verification
The hardest case to reach is a pointer outside the aperture. Its truncated index aliases onto a real entry: a pointer one page past the end wraps to entry 0, and a pointer just below the base wraps to the last entry. The bench maps the last page first and leaves entry 0 unmapped. It then writes data through both out-of-range pointers. Afterwards it reads both aliased entries back through a legal pointer and translates addresses in both pages, so that a lost range guard shows up at the ports. The aperture edges are covered by requests whose last byte sits exactly on, or one past, the end.

// File: rtl/apr_pkg.sv
package apr_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_PTR    = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/apr_table.sv
module apr_table #(
    parameter int NUM_PAGES = 16,
    parameter int ENT_W     = 20,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [ENT_W-1:0] rd_a_ent,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [ENT_W-1:0] rd_b_ent
);
    typedef struct packed {
        logic [NUM_PAGES-1:0][ENT_W-1:0] ent;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.ent[wr_idx] = wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_a_ent = st_q.ent[rd_a_idx];
    assign rd_b_ent = st_q.ent[rd_b_idx];

    // R4: a write lands in the addressed entry
    assert_entry_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.ent[$past(wr_idx)] == $past(wr_ent));
endmodule

// File: rtl/apr_regport.sv
module apr_regport
    import apr_pkg::*;
#(
    parameter int          NUM_PAGES = 16,
    parameter int          PAGE_BITS = 12,
    parameter logic [31:0] APT_BASE  = 32'h4000_0000,
    parameter int          ENT_W     = 20,
    parameter int          IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             xl_en,
    output logic             tbl_wr_en,
    output logic [IDX_W-1:0] tbl_wr_idx,
    output logic [ENT_W-1:0] tbl_wr_ent,
    output logic [IDX_W-1:0] tbl_rd_idx,
    input  logic [ENT_W-1:0] tbl_rd_ent
);
    localparam logic [32:0] APT_END = 33'(APT_BASE) + (33'(NUM_PAGES) << PAGE_BITS);

    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] ptr;
        logic [REG_W-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;
    reg_sel_e    sel;
    logic        ptr_ok;
    logic [IDX_W-1:0] ptr_idx;

    always_comb begin
        sel     = (reg_addr[1:0] == 2'b00) ? reg_sel_e'(reg_addr[3:2]) : SEL_NONE;
        ptr_ok  = (33'(st_q.ptr) >= 33'(APT_BASE)) && (33'(st_q.ptr) < APT_END);
        ptr_idx = IDX_W'((st_q.ptr - APT_BASE) >> PAGE_BITS);

        st_d = st_q;
        if (reg_wr) begin
            case (sel)
                SEL_ENABLE: st_d.en  = reg_wdata[0];
                SEL_PTR:    st_d.ptr = reg_wdata;
                default:    ;
            endcase
        end
        if (reg_rd) begin
            case (sel)
                SEL_ENABLE: st_d.rdata = {{(REG_W-1){1'b0}}, st_q.en};
                SEL_PTR:    st_d.rdata = st_q.ptr;
                SEL_DATA:   st_d.rdata = ptr_ok ? {tbl_rd_ent, {PAGE_BITS{1'b0}}} : '0;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata  = st_q.rdata;
    assign xl_en      = st_q.en;
    assign tbl_wr_en  = reg_wr && (sel == SEL_DATA) && ptr_ok;
    assign tbl_wr_idx = ptr_idx;
    assign tbl_wr_ent = reg_wdata[REG_W-1:PAGE_BITS];
    assign tbl_rd_idx = ptr_idx;

    // R2: enable register follows bit 0 of a write
    assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'h0) |=> xl_en == $past(reg_wdata[0]));
    // R3: pointer read returns the stored pointer
    assert_ptr_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == 4'h4) |=> reg_rdata == $past(st_q.ptr));
    // R5: out-of-aperture pointer reads as zero
    assert_oob_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 4'h8 && !ptr_ok) |=> reg_rdata == '0);
endmodule

// File: rtl/apr_xlate.sv
module apr_xlate #(
    parameter int          NUM_PAGES = 16,
    parameter int          PAGE_BITS = 12,
    parameter logic [31:0] APT_BASE  = 32'h4000_0000,
    parameter int          ENT_W     = 20,
    parameter int          IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xl_en,
    input  logic                 req_valid,
    input  logic [31:0]          req_addr,
    input  logic [PAGE_BITS-1:0] req_len,
    output logic [IDX_W-1:0]     lk_idx,
    input  logic [ENT_W-1:0]     lk_ent,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [31:0]          rsp_paddr
);
    localparam logic [32:0] APT_END = 33'(APT_BASE) + (33'(NUM_PAGES) << PAGE_BITS);

    typedef struct packed {
        logic        valid;
        logic        fault;
        logic [31:0] paddr;
    } rsp_state_t;

    rsp_state_t st_d, st_q;
    logic [32:0] last_byte;
    logic        in_range;
    logic        hit;

    always_comb begin
        last_byte = 33'(req_addr) + 33'(req_len);
        in_range  = (33'(req_addr) >= 33'(APT_BASE)) && (last_byte < APT_END);
        lk_idx    = IDX_W'((req_addr - APT_BASE) >> PAGE_BITS);
        hit       = xl_en && in_range && lk_ent[ENT_W-1];

        st_d.valid = req_valid;
        st_d.fault = req_valid && !hit;
        st_d.paddr = (req_valid && hit)
                   ? {1'b0, lk_ent[ENT_W-2:0], req_addr[PAGE_BITS-1:0]} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_fault = st_q.fault;
    assign rsp_paddr = st_q.paddr;

    // R6: one response per request, one cycle later
    assert_rsp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R7: disabled translation always faults
    assert_disabled_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !xl_en) |=> rsp_fault);
    // R8: a fault carries a zero address and is a response
    assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));
    // R10: page offset is passed through on a hit
    assert_offset_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> rsp_paddr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0]));
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import apr_pkg::*;
#(
    parameter int          NUM_PAGES = 16,
    parameter int          PAGE_BITS = 12,
    parameter logic [31:0] APT_BASE  = 32'h4000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [3:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 req_valid,
    input  logic [31:0]          req_addr,
    input  logic [PAGE_BITS-1:0] req_len,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [31:0]          rsp_paddr
);
    localparam int ENT_W = REG_W - PAGE_BITS;
    localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    logic             xl_en;
    logic             tbl_wr_en;
    logic [IDX_W-1:0] tbl_wr_idx, tbl_rd_idx, lk_idx;
    logic [ENT_W-1:0] tbl_wr_ent, tbl_rd_ent, lk_ent;

    apr_regport #(
        .NUM_PAGES(NUM_PAGES), .PAGE_BITS(PAGE_BITS), .APT_BASE(APT_BASE),
        .ENT_W(ENT_W), .IDX_W(IDX_W)
    ) regport_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xl_en(xl_en),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_ent(tbl_wr_ent),
        .tbl_rd_idx(tbl_rd_idx), .tbl_rd_ent(tbl_rd_ent)
    );

    apr_table #(
        .NUM_PAGES(NUM_PAGES), .ENT_W(ENT_W), .IDX_W(IDX_W)
    ) table_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_ent(tbl_wr_ent),
        .rd_a_idx(tbl_rd_idx), .rd_a_ent(tbl_rd_ent),
        .rd_b_idx(lk_idx), .rd_b_ent(lk_ent)
    );

    apr_xlate #(
        .NUM_PAGES(NUM_PAGES), .PAGE_BITS(PAGE_BITS), .APT_BASE(APT_BASE),
        .ENT_W(ENT_W), .IDX_W(IDX_W)
    ) xlate_i (
        .clk(clk), .rst_n(rst_n), .xl_en(xl_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .lk_idx(lk_idx), .lk_ent(lk_ent),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );
endmodule

// File: tb/aperture_remap_tb_top.sv
`timescale 1ns/1ps
module aperture_remap_tb_top;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [11:0] req_len = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    aperture_remap dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] off, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = off;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic map_page(input logic [31:0] va, input logic [31:0] ent);
        reg_write(4'h4, va);
        reg_write(4'h8, ent);
    endtask

    task automatic xlate(input logic [31:0] a, input logic [11:0] len,
                         output logic v, output logic f, output logic [31:0] pa);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        v = rsp_valid; f = rsp_fault; pa = rsp_paddr;
    endtask

    task automatic expect_hit(input string tag, input logic [31:0] a, input logic [11:0] len,
                              input logic [31:0] exp_pa);
        logic v, f;
        logic [31:0] pa;
        xlate(a, len, v, f, pa);
        check({tag, " valid"}, 32'(v), 32'd1);
        check({tag, " fault"}, 32'(f), 32'd0);
        check({tag, " paddr"}, pa, exp_pa);
    endtask

    task automatic expect_fault(input string tag, input logic [31:0] a, input logic [11:0] len);
        logic v, f;
        logic [31:0] pa;
        xlate(a, len, v, f, pa);
        check({tag, " valid"}, 32'(v), 32'd1);
        check({tag, " fault"}, 32'(f), 32'd1);
        check({tag, " paddr"}, pa, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
        reg_read(4'h0, d);            check("R1 enable after reset", d, 32'd0);
        reg_write(4'h4, BASE);
        reg_read(4'h8, d);            check("R1 entry after reset", d, 32'd0);
        expect_fault("R1 request after reset", BASE + 32'h10, 12'd3);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        reg_write(4'h0, 32'hFFFF_FFFF);
        reg_read(4'h0, d);            check("R2 enable readback", d, 32'd1);
    endtask

    task automatic t_pointer();
        logic [31:0] d;
        reg_write(4'h4, 32'h4000_3ABC);
        reg_read(4'h4, d);            check("R3 pointer readback", d, 32'h4000_3ABC);
    endtask

    task automatic t_entry();
        logic [31:0] d;
        reg_write(4'h8, 32'h8001_2FFF);
        reg_read(4'h8, d);            check("R4 entry readback", d, 32'h8001_2000);
        map_page(BASE + 32'h5000, 32'h8ABC_D000);
        map_page(BASE + 32'hF000, 32'h8007_7000);
        reg_write(4'h4, BASE + 32'h5FFF);
        reg_read(4'h8, d);            check("R4 entry page5", d, 32'h8ABC_D000);
    endtask

    task automatic t_translate();
        expect_hit("R6 page3", 32'h4000_3ABC, 12'd3, 32'h0001_2ABC);
        expect_hit("R6 R10 page5 bit31 stripped", 32'h4000_5123, 12'd0, 32'h0ABC_D123);
        expect_hit("R8 last byte at end", 32'h4000_F000, 12'hFFF, 32'h0007_7000);
    endtask

    task automatic t_range();
        expect_fault("R8 last byte past end", 32'h4000_FFF0, 12'h010);
        expect_fault("R8 below base", 32'h3FFF_FFFC, 12'd3);
        expect_fault("R8 at end", 32'h4001_0000, 12'd0);
    endtask

    task automatic t_oob_pointer();
        logic [31:0] d;
        reg_write(4'h4, 32'h4001_0000);
        reg_write(4'h8, 32'h8005_5000);
        reg_read(4'h8, d);            check("R5 read past end", d, 32'd0);
        reg_write(4'h4, 32'h3FFF_F000);
        reg_write(4'h8, 32'h0000_0000);
        reg_read(4'h8, d);            check("R5 read below base", d, 32'd0);
        reg_write(4'h4, BASE);
        reg_read(4'h8, d);            check("R5 entry0 untouched", d, 32'd0);
        reg_write(4'h4, BASE + 32'hF000);
        reg_read(4'h8, d);            check("R5 entry15 untouched", d, 32'h8007_7000);
        expect_fault("R5 page0 still unmapped", BASE + 32'h40, 12'd0);
        expect_hit("R5 page15 still mapped", BASE + 32'hF008, 12'd0, 32'h0007_7008);
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        expect_fault("R9 never mapped page7", BASE + 32'h7000, 12'd0);
        map_page(BASE + 32'h3000, 32'h0000_0000);
        reg_read(4'h8, d);            check("R9 unmapped readback", d, 32'd0);
        expect_fault("R9 unmapped page3", 32'h4000_3ABC, 12'd3);
        map_page(BASE + 32'h6000, 32'h0003_3000);
        expect_fault("R9 valid bit clear", BASE + 32'h6000, 12'd0);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        reg_write(4'h0, 32'd0);
        reg_read(4'h0, d);            check("R2 disable readback", d, 32'd0);
        expect_fault("R7 disabled page5", 32'h4000_5123, 12'd0);
        reg_write(4'h0, 32'd1);
        expect_hit("R7 re-enabled page5", 32'h4000_5123, 12'd0, 32'h0ABC_D123);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_pointer();
        t_entry();
        t_translate();
        t_range();
        t_oob_pointer();
        t_invalid();
        t_disable();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule